// File: doc/BRIEF.md
# Hotplug Slot Event Register Block

This block is a byte-wide register file that software polls to learn about hot-add and hot-remove events on a small set of expansion slots. It also lets software eject a slot. The platform side raises an add or remove request for a slot index. The block records the event in a packed descriptor and keeps a presence flag for every slot. It drives a level power-enable for each slot. For every accepted request it sends a single-cycle event pulse to the general-purpose-event logic, which generates the interrupt.

Offset 0 holds the descriptor. Offsets 1 to NUM_SLOTS each report the presence of one slot. Software reads these offsets, finds the slot that changed, and finishes a removal by writing the eject command to that slot's offset. The block checks every request index against the number of slots. An index that is out of range is dropped without touching any state, and the block flags it with a one-cycle error pulse. Reads are combinational. Writes and requests take effect at the clock edge.

Top module: `hpslot_evt_ctrl`

## Requirements
- R1: After reset, slot k reads 0x0F if bit k of PRESENT_MASK is set and 0x00 otherwise. slot_pwr equals PRESENT_MASK, the descriptor reads 0x00, and evt_pulse and req_err are low.
- R2: reg_rdata shows the descriptor at offset 0. It shows the status of slot k-1 at offset k for k in 1..NUM_SLOTS, which is 0x0F when the slot is present and 0x00 when it is empty. Every higher offset reads 0x00.
- R3: An accepted add request for slot s sets the descriptor to {s+1 in bits 7:4, 0x0 in bits 3:0}. It marks slot s present (0x0F) and drives slot_pwr[s] high. All of this is visible after the next clock edge.
- R4: An accepted remove request for slot s sets the descriptor to {s+1 in bits 7:4, 0x3 in bits 3:0}. It leaves the status and power of slot s unchanged.
- R5: Writing 0x01 to offset k (1..NUM_SLOTS) ejects slot k-1. Its status becomes 0x00, the descriptor becomes 0x00 and slot_pwr[k-1] goes low.
- R6: A write of any value other than 0x01 to a slot offset has no effect. So does any write to offset 0 or to an offset above NUM_SLOTS.
- R7: A request whose slot index is NUM_SLOTS or more changes no state. It raises req_err for exactly the one cycle after the request.
- R8: An accepted request raises evt_pulse for exactly the one cycle after the request. evt_pulse and req_err are never high together.
- R9: When add_req and rem_req are high in the same cycle, only the add is performed.
- R10: When a request and an eject write fall in the same cycle, the eject is applied first and the request's updates are applied on top. The descriptor comes from the request, and an add of the ejected slot leaves it present and powered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register offset for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| add_req | input | 1 | Hot-add request for req_slot |
| rem_req | input | 1 | Hot-remove request for req_slot |
| req_slot | input | REQ_W | Slot index of the request |
| slot_pwr | output | NUM_SLOTS | Per-slot power enable, level |
| evt_pulse | output | 1 | One-cycle event request to the general-purpose-event logic |
| req_err | output | 1 | One-cycle flag for a rejected request |

## Verification
The bench targets the asymmetry between add and remove. A remove that cleared the presence flag or dropped power would show a slot as empty before software had ejected it. It also checks that an eject clears the descriptor, because a design that left it set would report a stale event on the next poll. Requests with indices just past the last slot check the range test. An off-by-one compare there would corrupt a nonexistent slot's state, or a real slot's state, and would pulse evt_pulse where req_err is expected. The bench also drives simultaneous add/remove and request-plus-eject cycles, where the wrong precedence shows up as a remove code in the descriptor or as a slot that is freshly added but unpowered.

// File: rtl/hpslot_pkg.sv
package hpslot_pkg;
   localparam logic [3:0] EVT_CODE_ADD = 4'h0;
   localparam logic [3:0] EVT_CODE_REM = 4'h3;
   localparam logic [7:0] STS_PRESENT  = 8'h0F;
   localparam logic [7:0] STS_EMPTY    = 8'h00;
   localparam logic [7:0] CMD_EJECT    = 8'h01;

   function automatic logic [7:0] pack_desc(input logic [3:0] slot_plus1, input logic is_add);
      return {slot_plus1, is_add ? EVT_CODE_ADD : EVT_CODE_REM};
   endfunction
endpackage

// File: rtl/hpslot_decode.sv
module hpslot_decode
   import hpslot_pkg::*;
#(
   parameter int NUM_SLOTS = 4,
   parameter int ADDR_W    = 4
) (
   input  logic                 reg_wr,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [7:0]           reg_wdata,
   input  logic [7:0]           desc,
   input  logic [NUM_SLOTS-1:0] present,
   output logic [NUM_SLOTS-1:0] eject,
   output logic [7:0]           rdata
);
   localparam logic [ADDR_W-1:0] LAST_OFS = ADDR_W'(NUM_SLOTS);

   logic cmd_ok;
   assign cmd_ok = reg_wr && (reg_wdata == CMD_EJECT);

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_ej
      assign eject[i] = cmd_ok && (reg_addr == ADDR_W'(i + 1));
   end

   always_comb begin
      rdata = STS_EMPTY;
      if (reg_addr == '0) begin
         rdata = desc;
      end else if (reg_addr <= LAST_OFS) begin
         for (int i = 0; i < NUM_SLOTS; i++) begin
            if (reg_addr == ADDR_W'(i + 1)) rdata = present[i] ? STS_PRESENT : STS_EMPTY;
         end
      end
   end
endmodule

// File: rtl/hpslot_slot.sv
module hpslot_slot #(
   parameter bit INIT_PRESENT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic add_i,
   input  logic rem_i,
   input  logic eject_i,
   output logic present,
   output logic pwr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         present <= INIT_PRESENT;
         pwr     <= INIT_PRESENT;
      end else if (add_i) begin
         present <= 1'b1;
         pwr     <= 1'b1;
      end else if (eject_i) begin
         present <= 1'b0;
         pwr     <= 1'b0;
      end
   end

   a_r3_add_powers: assert property (@(posedge clk) disable iff (!rst_n)
      add_i |=> (present && pwr));
   a_r5_eject_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (eject_i && !add_i) |=> (!present && !pwr));
   a_r4_remove_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (rem_i && !add_i && !eject_i) |=> ($stable(present) && $stable(pwr)));
endmodule

// File: rtl/hpslot_desc.sv
module hpslot_desc
   import hpslot_pkg::*;
#(
   parameter int NUM_SLOTS = 4,
   parameter int REQ_W     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             add_req,
   input  logic             rem_req,
   input  logic [REQ_W-1:0] req_slot,
   input  logic             any_eject,
   output logic             req_ok,
   output logic [7:0]       desc,
   output logic             evt_pulse,
   output logic             req_err
);
   localparam logic [REQ_W-1:0] SLOT_LIM = REQ_W'(NUM_SLOTS);

   logic req_any;
   assign req_any = add_req || rem_req;
   assign req_ok  = req_any && (req_slot < SLOT_LIM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         desc      <= '0;
         evt_pulse <= 1'b0;
         req_err   <= 1'b0;
      end else begin
         evt_pulse <= req_ok;
         req_err   <= req_any && !req_ok;
         if (req_ok)         desc <= pack_desc(4'(req_slot + 1'b1), add_req);
         else if (any_eject) desc <= '0;
      end
   end

   a_r7_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (req_any && !req_ok && !any_eject) |=> $stable(desc));
   a_r9_add_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ok && add_req) |=> (desc[3:0] == EVT_CODE_ADD));
   a_r5_eject_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
      (any_eject && !req_any) |=> (desc == 8'h00));
endmodule

// File: rtl/hpslot_evt_ctrl.sv
module hpslot_evt_ctrl
   import hpslot_pkg::*;
#(
   parameter int                 NUM_SLOTS    = 4,
   parameter int                 ADDR_W       = 4,
   parameter int                 REQ_W        = 4,
   parameter logic [NUM_SLOTS-1:0] PRESENT_MASK = 4'b0101
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [7:0]           reg_wdata,
   output logic [7:0]           reg_rdata,
   input  logic                 add_req,
   input  logic                 rem_req,
   input  logic [REQ_W-1:0]     req_slot,
   output logic [NUM_SLOTS-1:0] slot_pwr,
   output logic                 evt_pulse,
   output logic                 req_err
);
   if (NUM_SLOTS < 1 || NUM_SLOTS > 15) begin : g_bad_slots
      $error("NUM_SLOTS must lie in 1..15 to fit the descriptor slot field");
   end
   if ((1 << ADDR_W) <= NUM_SLOTS) begin : g_bad_addr
      $error("ADDR_W too narrow for NUM_SLOTS offsets");
   end
   if ((1 << REQ_W) <= NUM_SLOTS) begin : g_bad_req
      $error("REQ_W too narrow to name every slot");
   end

   logic [NUM_SLOTS-1:0] present, eject;
   logic [7:0]           desc;
   logic                 req_ok;

   hpslot_decode #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_dec (
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .desc(desc), .present(present), .eject(eject), .rdata(reg_rdata)
   );

   hpslot_desc #(.NUM_SLOTS(NUM_SLOTS), .REQ_W(REQ_W)) u_desc (
      .clk(clk), .rst_n(rst_n), .add_req(add_req), .rem_req(rem_req),
      .req_slot(req_slot), .any_eject(|eject), .req_ok(req_ok),
      .desc(desc), .evt_pulse(evt_pulse), .req_err(req_err)
   );

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      logic hit;
      assign hit = req_ok && (req_slot == REQ_W'(i));
      hpslot_slot #(.INIT_PRESENT(PRESENT_MASK[i])) u_slot (
         .clk(clk), .rst_n(rst_n),
         .add_i(hit && add_req), .rem_i(hit && !add_req), .eject_i(eject[i]),
         .present(present[i]), .pwr(slot_pwr[i])
      );
   end

   a_r8_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(evt_pulse && req_err));
   a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_pulse && !req_ok) |=> !evt_pulse);
endmodule

// File: tb/hpslot_evt_ctrl_tb_top.sv
`timescale 1ns/100ps
module hpslot_evt_ctrl_tb_top;
   localparam int N = 4;
   localparam logic [N-1:0] MASK = 4'b0101;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_wr = 1'b0;
   logic [3:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic add_req = 1'b0, rem_req = 1'b0;
   logic [3:0] req_slot = '0;
   logic [N-1:0] slot_pwr;
   logic evt_pulse, req_err;

   int total = 0, bad = 0;
   logic [7:0] m_desc;
   logic [N-1:0] m_pres, m_pwr;

   always #5 clk = ~clk;

   hpslot_evt_ctrl #(.NUM_SLOTS(N), .ADDR_W(4), .REQ_W(4), .PRESENT_MASK(MASK)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .add_req(add_req),
      .rem_req(rem_req), .req_slot(req_slot), .slot_pwr(slot_pwr),
      .evt_pulse(evt_pulse), .req_err(req_err)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_read(input int a);
      if (a == 0) return m_desc;
      if (a <= N) return m_pres[a-1] ? 8'h0F : 8'h00;
      return 8'h00;
   endfunction

   task automatic sweep(input string req);
      for (int a = 0; a < 16; a++) begin
         reg_addr = 4'(a);
         #0.5;
         chk(req, {24'h0, reg_rdata}, {24'h0, exp_read(a)});
      end
   endtask

   // one transaction: drive at negedge, check registered outputs at next negedge
   task automatic apply(input string req, input logic wr, input logic [3:0] addr,
                        input logic [7:0] data, input logic ad, input logic rm,
                        input logic [3:0] s);
      logic ok, any;
      @(negedge clk);
      reg_wr = wr; reg_addr = addr; reg_wdata = data;
      add_req = ad; rem_req = rm; req_slot = s;
      @(negedge clk);
      any = ad || rm;
      ok  = any && (s < N);
      if (wr && data == 8'h01 && addr >= 1 && addr <= N) begin
         m_pres[addr-1] = 1'b0; m_pwr[addr-1] = 1'b0; m_desc = 8'h00;
      end
      if (ok) begin
         m_desc = {4'(s + 1), ad ? 4'h0 : 4'h3};
         if (ad) begin m_pres[s[1:0]] = 1'b1; m_pwr[s[1:0]] = 1'b1; end
      end
      chk({req, " R8 evt"}, {31'h0, evt_pulse}, {31'h0, ok});
      chk({req, " R7 err"}, {31'h0, req_err}, {31'h0, any && !ok});
      chk({req, " pwr"}, {28'h0, slot_pwr}, {28'h0, m_pwr});
      reg_wr = 1'b0; add_req = 1'b0; rem_req = 1'b0;
      sweep(req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'd20240611);
      m_desc = 8'h00; m_pres = MASK; m_pwr = MASK;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state, R2 read map
      chk("R1 pwr", {28'h0, slot_pwr}, {28'h0, MASK});
      chk("R1 evt", {31'h0, evt_pulse}, 32'h0);
      chk("R1 err", {31'h0, req_err}, 32'h0);
      sweep("R1 R2 reset map");
      // R3 add on empty slot 1
      apply("R3 add", 1'b0, 4'd0, 8'h0, 1'b1, 1'b0, 4'd1);
      chk("R3 desc", {24'h0, exp_read(0)}, 32'h20);
      // R4 remove slot 0 keeps status
      apply("R4 remove", 1'b0, 4'd0, 8'h0, 1'b0, 1'b1, 4'd0);
      chk("R4 desc", {24'h0, m_desc}, 32'h13);
      // R6 ignored writes
      apply("R6 bad cmd", 1'b1, 4'd1, 8'h02, 1'b0, 1'b0, 4'd0);
      apply("R6 ofs0", 1'b1, 4'd0, 8'h01, 1'b0, 1'b0, 4'd0);
      apply("R6 ofs high", 1'b1, 4'd5, 8'h01, 1'b0, 1'b0, 4'd0);
      // R5 eject slot 0
      apply("R5 eject", 1'b1, 4'd1, 8'h01, 1'b0, 1'b0, 4'd0);
      // R7 out-of-range indices
      apply("R7 edge", 1'b0, 4'd0, 8'h0, 1'b1, 1'b0, 4'd4);
      apply("R7 far", 1'b0, 4'd0, 8'h0, 1'b0, 1'b1, 4'd15);
      // R9 add and remove together
      apply("R9 both", 1'b0, 4'd0, 8'h0, 1'b1, 1'b1, 4'd3);
      chk("R9 code", {28'h0, m_desc[3:0]}, 32'h0);
      // R10 eject and add same slot same cycle
      apply("R10 ej+add", 1'b1, 4'd4, 8'h01, 1'b1, 1'b0, 4'd3);
      apply("R10 ej+rem", 1'b1, 4'd2, 8'h01, 1'b0, 1'b1, 4'd0);
      // random mix
      for (int n = 0; n < 400; n++) begin
         logic w, ad, rm;
         logic [3:0] a, s;
         logic [7:0] d;
         w  = ($urandom % 3) == 0;
         a  = 4'($urandom % 7);
         d  = ($urandom % 2) ? 8'h01 : 8'($urandom);
         ad = ($urandom % 3) == 0;
         rm = ($urandom % 3) == 0;
         s  = 4'($urandom % 7);
         apply("R3 R4 R5 R6 R7 R8 random", w, a, d, ad, rm, s);
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule